// File: doc/BRIEF.md
# Two-Bank SDRAM Read Command Sequencer

This block turns single read requests into command sequences for a synchronous DRAM with two independent banks. Each request names a bank, a row, a column and an optional close-after-read flag. The block remembers which row is open in each bank. It opens, closes and reads rows as needed, and it spaces every command with per-bank and cross-bank cycle counters. The burst that the DRAM returns after the CAS latency is captured and handed back with a valid strobe and a last-word marker.

Commands go out on registered pins. The command code is 2'b00 for no operation, 2'b01 for activate, 2'b10 for read and 2'b11 for precharge. The bank goes on a one-bit select and row or column goes on the address bus. Address bit `AP_BIT` (default 10) carries the close-all flag on a precharge and the auto-precharge flag on a read. The request port has a valid/ready handshake and takes one request at a time. A new request can still be accepted while the previous burst is streaming, so activating one bank overlaps data from the other.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_o` is 2'b00, `req_ready` is high and `rd_valid` is low.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle in which that request's read command is on the bus, and is high again in that cycle.
- R3: A request to an open bank whose row matches issues only a read. A request to a closed bank issues activate then read. A request to an open bank with another row issues precharge, then activate, then read. Activate drives the row on `addr_o`. Read drives the column on `addr_o[COL_W-1:0]`, the auto-precharge flag on `addr_o[AP_BIT]` and zeros elsewhere. `ba_o` always carries the requested bank.
- R4: Two activate commands are at least `T_RRD` cycles apart.
- R5: A read to a bank comes at least `T_RCD` cycles after that bank's activate.
- R6: A precharge closing a bank comes at least `T_RAS` cycles after that bank's activate.
- R7: An activate to a bank comes at least `T_RP` cycles after the precharge that closed it, and only to a closed bank.
- R8: Two read commands are at least `BURST` cycles apart, so bursts never overlap on the data pins.
- R9: A read with `req_autopre` set drives `addr_o[AP_BIT]`=1 and leaves the bank closed. It is issued no earlier than `T_RAS-(CAS_LAT+BURST-2)` cycles after the activate. The next activate to that bank waits `CAS_LAT+BURST-2+T_RP` cycles after the read, and needs no precharge command.
- R10: When a precharge is needed while the other bank is also open, a single precharge with `addr_o[AP_BIT]`=1 closes both banks. With only the target bank open, `addr_o[AP_BIT]`=0.
- R11: Read data word i is sampled from `dram_dq` `CAS_LAT+i` cycles after the read command and appears on `rd_data` with `rd_valid` high one cycle later, for i = 0..`BURST-1`. `rd_last` is high with the final word only.
- R12: `cmd_o` is 2'b00 on every cycle that carries no command of the sequences in R3.
- R13: Each command is issued in the first cycle that its windows allow. The first command of a request appears two cycles after the accepting edge's cycle, and each later one comes no sooner than the cycle after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_bank | input | 1 | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Close the bank after this read |
| cmd_o | output | 2 | Command code (see R3, R12) |
| ba_o | output | 1 | Bank select |
| addr_o | output | ROW_W | Row, column and flag bit |
| dram_dq | input | DATA_W | Read data from the DRAM |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_last | output | 1 | Final word of a burst |

## Verification
The bench hits the corner where a row miss meets an open neighbour bank. A design that closed only the target bank there would break R10, and one that lost track of the closed neighbour would later read it without an activate. An auto-precharge read is followed at once by a request to the same bank. A sequencer that ignored the hidden precharge would activate too early or send a needless precharge. Back-to-back row hits and alternating banks test the read spacing and the activate spacing, where an off-by-one counter load shows up as a command one cycle early or late. Each burst's data is checked word by word against the DRAM model, so a wrong CAS latency gives shifted data or a misplaced `rd_last`.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_RD
  } st_e;
endpackage

// File: rtl/rdseq_cnt.sv
// Loadable down counter that stops at zero.
module rdseq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                value <= '0;
    else if (load)          value <= load_val;
    else if (value != '0)   value <= value - W'(1);
  end
endmodule

// File: rtl/rdseq_bank.sv
// State of one bank: open flag, open row and its three timing windows.
module rdseq_bank #(
  parameter int ROW_W  = 12,
  parameter int CNT_W  = 4,
  parameter int T_RAS  = 5,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int AP_OFF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic [ROW_W-1:0] act_row,
  input  logic             pre,
  input  logic             rd_ap,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rcd_ok,
  output logic             ras_ok,
  output logic             ap_ok,
  output logic             rp_ok
);
  logic [CNT_W-1:0] rcd_v, ras_v, rp_v, rp_load;

  // A counter loaded with N-1 reads zero in the cycle before the first
  // legal issue cycle, matching the registered command output.
  assign rp_load = rd_ap ? CNT_W'(AP_OFF + T_RP - 1) : CNT_W'(T_RP - 1);

  rdseq_cnt #(.W(CNT_W)) u_rcd (
    .clk(clk), .rst(rst), .load(act), .load_val(CNT_W'(T_RCD - 1)), .value(rcd_v));
  rdseq_cnt #(.W(CNT_W)) u_ras (
    .clk(clk), .rst(rst), .load(act), .load_val(CNT_W'(T_RAS - 1)), .value(ras_v));
  rdseq_cnt #(.W(CNT_W)) u_rp (
    .clk(clk), .rst(rst), .load(pre | rd_ap), .load_val(rp_load), .value(rp_v));

  assign rcd_ok = (rcd_v == '0);
  assign ras_ok = (ras_v == '0);
  assign rp_ok  = (rp_v == '0);
  // internal precharge starts AP_OFF cycles after the read; it must not beat tRAS
  assign ap_ok  = (ras_v <= CNT_W'(AP_OFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (act) begin
      is_open  <= 1'b1;
      open_row <= act_row;
    end else if (pre | rd_ap) begin
      is_open  <= 1'b0;
    end
  end
endmodule

// File: rtl/rdseq_capture.sv
// Tracks issued reads through the CAS latency and captures each burst.
module rdseq_capture #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 3,
  parameter int BURST   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last
);
  localparam int PIPE = CAS_LAT + BURST;

  logic [PIPE-1:0] pipe;
  logic            window;

  assign window = |pipe[PIPE-1:CAS_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[PIPE-2:0], rd_issue};
      rd_valid <= window;
      rd_last  <= pipe[PIPE-1];
      if (window) rd_data <= dq;
    end
  end
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import rdseq_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 16,
  parameter int AP_BIT  = 10,
  parameter int T_RAS   = 5,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RRD   = 2,
  parameter int CAS_LAT = 3,
  parameter int BURST   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic [1:0]        cmd_o,
  output logic              ba_o,
  output logic [ROW_W-1:0]  addr_o,
  input  logic [DATA_W-1:0] dram_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last
);
  localparam int AP_OFF = CAS_LAT + BURST - 2;
  localparam int CNT_W  = $clog2(AP_OFF + T_RP + T_RAS + T_RCD + T_RRD + BURST + 1);

  st_e              st;
  logic             q_bank, q_ap;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;

  logic [1:0]       b_open, rcd_ok, ras_ok, ap_ok, rp_ok;
  logic [ROW_W-1:0] b_row [2];
  logic [1:0]       act_go, pre_go, rdap_go;

  logic [CNT_W-1:0] rrd_v, rr_v;
  logic             accept, other, pre_all;
  logic             pre_fire, act_fire, rd_fire;
  logic [ROW_W-1:0] rd_addr, pre_addr;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign other     = ~q_bank;
  assign pre_all   = b_open[other];

  assign pre_fire = (st == ST_PRE) && ras_ok[q_bank] && (!b_open[other] || ras_ok[other]);
  assign act_fire = (st == ST_ACT) && rp_ok[q_bank] && (rrd_v == '0);
  assign rd_fire  = (st == ST_RD) && rcd_ok[q_bank] && (rr_v == '0) &&
                    (!q_ap || ap_ok[q_bank]);

  always_comb begin
    act_go  = '0;
    pre_go  = '0;
    rdap_go = '0;
    if (act_fire) act_go[q_bank] = 1'b1;
    if (pre_fire) begin
      pre_go[q_bank] = 1'b1;
      if (pre_all) pre_go[other] = 1'b1;
    end
    if (rd_fire && q_ap) rdap_go[q_bank] = 1'b1;
  end

  for (genvar i = 0; i < 2; i++) begin : g_bank
    rdseq_bank #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RAS(T_RAS), .T_RCD(T_RCD),
      .T_RP(T_RP), .AP_OFF(AP_OFF)
    ) u_bank (
      .clk(clk), .rst(rst),
      .act(act_go[i]), .act_row(q_row), .pre(pre_go[i]), .rd_ap(rdap_go[i]),
      .is_open(b_open[i]), .open_row(b_row[i]),
      .rcd_ok(rcd_ok[i]), .ras_ok(ras_ok[i]), .ap_ok(ap_ok[i]), .rp_ok(rp_ok[i])
    );
  end

  // cross-bank activate spacing and read-to-read spacing
  rdseq_cnt #(.W(CNT_W)) u_rrd (
    .clk(clk), .rst(rst), .load(act_fire), .load_val(CNT_W'(T_RRD - 1)), .value(rrd_v));
  rdseq_cnt #(.W(CNT_W)) u_rr (
    .clk(clk), .rst(rst), .load(rd_fire), .load_val(CNT_W'(BURST - 1)), .value(rr_v));

  always_comb begin
    rd_addr              = '0;
    rd_addr[COL_W-1:0]   = q_col;
    rd_addr[AP_BIT]      = q_ap;
    pre_addr             = '0;
    pre_addr[AP_BIT]     = pre_all;
  end

  // request sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      q_bank <= 1'b0;
      q_ap   <= 1'b0;
      q_row  <= '0;
      q_col  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          q_bank <= req_bank;
          q_row  <= req_row;
          q_col  <= req_col;
          q_ap   <= req_autopre;
          if (b_open[req_bank] && (b_row[req_bank] == req_row)) st <= ST_RD;
          else if (b_open[req_bank])                            st <= ST_PRE;
          else                                                  st <= ST_ACT;
        end
        ST_PRE:  if (pre_fire) st <= ST_ACT;
        ST_ACT:  if (act_fire) st <= ST_RD;
        ST_RD:   if (rd_fire)  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // registered command pins
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o  <= CMD_NOP;
      ba_o   <= 1'b0;
      addr_o <= '0;
    end else if (pre_fire) begin
      cmd_o  <= CMD_PRE;
      ba_o   <= q_bank;
      addr_o <= pre_addr;
    end else if (act_fire) begin
      cmd_o  <= CMD_ACT;
      ba_o   <= q_bank;
      addr_o <= q_row;
    end else if (rd_fire) begin
      cmd_o  <= CMD_RD;
      ba_o   <= q_bank;
      addr_o <= rd_addr;
    end else begin
      cmd_o  <= CMD_NOP;
      ba_o   <= 1'b0;
      addr_o <= '0;
    end
  end

  rdseq_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .BURST(BURST)) u_cap (
    .clk(clk), .rst(rst), .rd_issue(rd_fire), .dq(dram_dq),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last));
endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
  parameter int T_RAS = 5,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RRD = 2,
  parameter int BURST = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] cmd_o,
  input logic       ba_o,
  input logic       ap_flag
);
  logic [7:0] since_act [2];
  logic [7:0] since_pre [2];
  logic [7:0] since_any_act, since_rd;
  logic       is_act, is_rd, is_pre;

  assign is_act = (cmd_o == 2'b01);
  assign is_rd  = (cmd_o == 2'b10);
  assign is_pre = (cmd_o == 2'b11);

  // cycle distances since the last command of each kind, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      since_any_act <= 8'hFF;
      since_rd      <= 8'hFF;
      for (int i = 0; i < 2; i++) begin
        since_act[i] <= 8'hFF;
        since_pre[i] <= 8'hFF;
      end
    end else begin
      since_any_act <= is_act ? 8'd1 : (since_any_act == 8'hFF ? 8'hFF : since_any_act + 8'd1);
      since_rd      <= is_rd  ? 8'd1 : (since_rd == 8'hFF ? 8'hFF : since_rd + 8'd1);
      for (int i = 0; i < 2; i++) begin
        if (is_act && ba_o == i[0])                   since_act[i] <= 8'd1;
        else if (since_act[i] != 8'hFF)               since_act[i] <= since_act[i] + 8'd1;
        if (is_pre && (ap_flag || ba_o == i[0]))      since_pre[i] <= 8'd1;
        else if (since_pre[i] != 8'hFF)               since_pre[i] <= since_pre[i] + 8'd1;
      end
    end
  end

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R4
  rrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (32'(since_any_act) >= T_RRD));
  // R5
  rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> (32'(since_act[ba_o]) >= T_RCD));
  // R6
  ras_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_pre && !ap_flag) |-> (32'(since_act[ba_o]) >= T_RAS));
  // R6
  ras_all_chk: assert property (@(posedge clk) disable iff (rst)
    (is_pre && ap_flag) |-> (32'(since_act[0]) >= T_RAS && 32'(since_act[1]) >= T_RAS));
  // R7
  rp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (32'(since_pre[ba_o]) >= T_RP));
  // R8
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> (32'(since_rd) >= BURST));
endmodule

bind sdram_rd_seq rdseq_checker #(
  .T_RAS(T_RAS), .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .BURST(BURST)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_o(cmd_o), .ba_o(ba_o), .ap_flag(addr_o[AP_BIT])
);

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;
  localparam int ROW_W = 12, COL_W = 10, DATA_W = 16, APB = 10;
  localparam int T_RAS = 5, T_RCD = 3, T_RP = 3, T_RRD = 2, CL = 3, BL = 4;
  localparam int AP_OFF = CL + BL - 2;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic              req_valid = 1'b0, req_bank = 1'b0, req_autopre = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_ready, ba_o, rd_valid, rd_last;
  logic [1:0]        cmd_o;
  logic [ROW_W-1:0]  addr_o;
  logic [DATA_W-1:0] dram_dq = '0, rd_data;

  sdram_rd_seq u_sdram_rd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_autopre(req_autopre),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dram_dq(dram_dq),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [DATA_W-1:0] dword(bit b, logic [ROW_W-1:0] row,
                                              logic [COL_W-1:0] col, int i);
    logic [COL_W-1:0] c;
    c = {col[COL_W-1:2], 2'(col[1:0] + i[1:0])};
    return {b, row[4:0], c};
  endfunction

  typedef struct { int kind; bit bank; logic [ROW_W-1:0] addr; bit first; int acc; } ecmd_t;
  typedef struct { logic [DATA_W-1:0] d; bit last; } edat_t;
  ecmd_t cq[$];
  edat_t dq_q[$];

  // scoreboard driver: own view of open rows, computed from requests only
  bit               m_open [2];
  logic [ROW_W-1:0] m_row  [2];

  task automatic send(bit b, logic [ROW_W-1:0] row, logic [COL_W-1:0] col, bit ap);
    ecmd_t e;
    bit first = 1;
    @(negedge clk);
    req_valid = 1; req_bank = b; req_row = row; req_col = col; req_autopre = ap;
    while (!req_ready) @(negedge clk);
    if (!(m_open[b] && m_row[b] == row)) begin
      if (m_open[b]) begin
        e = '{3, b, '0, first, cyc};
        e.addr[APB] = m_open[!b];          // R10 close both when neighbour open
        cq.push_back(e); first = 0;
        if (m_open[!b]) m_open[!b] = 0;
        m_open[b] = 0;
      end
      e = '{1, b, row, first, cyc};
      cq.push_back(e); first = 0;
      m_open[b] = 1; m_row[b] = row;
    end
    e = '{2, b, '0, first, cyc};
    e.addr[COL_W-1:0] = col;
    e.addr[APB] = ap;
    cq.push_back(e);
    if (ap) m_open[b] = 0;
    for (int i = 0; i < BL; i++) dq_q.push_back('{dword(b, row, col, i), i == BL - 1});
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", "ready after accept", int'(req_ready), 0);
  endtask

  // DRAM model and monitor
  bit               d_open  [2];
  logic [ROW_W-1:0] d_row   [2];
  int               d_act   [2] = '{-1000, -1000};
  int               d_ready [2] = '{-1000, -1000};
  int               last_act = -1000, last_rd = -1000, prev_cyc = -1000;
  logic [DATA_W-1:0] sd [64];
  bit               sv [64], vv [64], vl [64];

  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_o != 2'b00) begin
        if (cq.size() == 0) begin
          chk(0, "R12", "unexpected command", int'(cmd_o), 0);
        end else begin
          ecmd_t e;
          int base, early;
          bit b;
          e = cq.pop_front();
          b = ba_o;
          chk(int'(cmd_o) == e.kind, "R3", "command kind", int'(cmd_o), e.kind);
          chk(ba_o == e.bank, "R3", "bank", int'(ba_o), int'(e.bank));
          if (e.kind == 3)
            chk(addr_o[APB] == e.addr[APB], "R10", "close-all flag", int'(addr_o[APB]), int'(e.addr[APB]));
          else if (e.kind == 2)
            chk(addr_o == e.addr, "R9", "read address and flag", int'(addr_o), int'(e.addr));
          else
            chk(addr_o == e.addr, "R3", "row address", int'(addr_o), int'(e.addr));
          base = e.first ? e.acc + 2 : prev_cyc + 1;
          case (e.kind)
            1: early = mx(base, mx(d_ready[e.bank], last_act + T_RRD));
            2: early = mx(mx(base, d_act[e.bank] + T_RCD),
                          mx(last_rd + BL, e.addr[APB] ? d_act[e.bank] + T_RAS - AP_OFF : 0));
            default: early = mx(mx(base, d_act[e.bank] + T_RAS),
                                e.addr[APB] ? d_act[!e.bank] + T_RAS : 0);
          endcase
          chk(cyc == early, "R13", "issue cycle", cyc, early);
          if (cmd_o == 2'b01) begin
            chk(!d_open[b], "R7", "activate to open bank", int'(d_open[b]), 0);
            chk(cyc >= d_ready[b], "R7", "activate after precharge", cyc, d_ready[b]);
            chk(cyc - last_act >= T_RRD, "R4", "activate spacing", cyc - last_act, T_RRD);
            d_open[b] = 1; d_row[b] = addr_o; d_act[b] = cyc; last_act = cyc;
          end else if (cmd_o == 2'b10) begin
            chk(d_open[b], "R5", "read to closed bank", int'(d_open[b]), 1);
            chk(cyc - d_act[b] >= T_RCD, "R5", "activate to read", cyc - d_act[b], T_RCD);
            chk(cyc - last_rd >= BL, "R8", "read spacing", cyc - last_rd, BL);
            chk(req_ready == 1, "R2", "ready with read", int'(req_ready), 1);
            for (int i = 0; i < BL; i++) begin
              int s, v;
              s = (cyc + CL + i) % 64;
              v = (cyc + CL + 1 + i) % 64;
              chk(!sv[s], "R8", "burst overlap", 1, 0);
              sd[s] = dword(b, d_row[b], addr_o[COL_W-1:0], i);
              sv[s] = 1; vv[v] = 1; vl[v] = (i == BL - 1);
            end
            if (addr_o[APB]) begin
              chk(cyc - d_act[b] >= T_RAS - AP_OFF, "R9", "auto-precharge vs tRAS", cyc - d_act[b], T_RAS - AP_OFF);
              d_open[b] = 0; d_ready[b] = cyc + AP_OFF + T_RP;
            end
            last_rd = cyc;
          end else begin
            if (addr_o[APB]) begin
              chk(d_open[0] && d_open[1], "R10", "close-all with both open", int'(d_open[0]) + int'(d_open[1]), 2);
              for (int i = 0; i < 2; i++) begin
                chk(cyc - d_act[i] >= T_RAS, "R6", "close-all vs tRAS", cyc - d_act[i], T_RAS);
                d_open[i] = 0; d_ready[i] = cyc + T_RP;
              end
            end else begin
              chk(d_open[b] && !d_open[!b], "R10", "single precharge", int'(d_open[!b]), 0);
              chk(cyc - d_act[b] >= T_RAS, "R6", "precharge vs tRAS", cyc - d_act[b], T_RAS);
              d_open[b] = 0; d_ready[b] = cyc + T_RP;
            end
          end
          prev_cyc = cyc;
        end
      end
      // data pins for this cycle
      begin
        int s;
        s = cyc % 64;
        dram_dq = sv[s] ? sd[s] : '0;
        sv[s] = 0;
      end
      // returned data
      begin
        int s;
        s = cyc % 64;
        if (rd_valid != vv[s])
          chk(0, "R11", "rd_valid timing", int'(rd_valid), int'(vv[s]));
        if (rd_valid) begin
          if (dq_q.size() == 0) chk(0, "R11", "extra word", int'(rd_data), 0);
          else begin
            edat_t x;
            x = dq_q.pop_front();
            chk(rd_data == x.d, "R11", "read word", int'(rd_data), int'(x.d));
            chk(rd_last == x.last, "R11", "last marker", int'(rd_last), int'(x.last));
          end
        end else if (rd_last) chk(0, "R11", "last without valid", 1, 0);
        vv[s] = 0; vl[s] = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R13", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_o == 2'b00, "R1", "cmd in reset", int'(cmd_o), 0);
    chk(req_ready == 1, "R1", "ready in reset", int'(req_ready), 1);
    chk(rd_valid == 0, "R1", "valid in reset", int'(rd_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(cmd_o == 2'b00 && req_ready && !rd_valid, "R1", "state after reset", int'(cmd_o), 0);

    send(0, 12'd5, 10'd8, 0);    // R3 closed bank
    send(0, 12'd5, 10'd9, 0);    // R3 row hit, R8 spacing
    send(1, 12'd7, 10'd0, 0);    // R4 other bank
    send(0, 12'd6, 10'd4, 0);    // R10 miss with both open
    send(1, 12'd7, 10'd2, 0);    // R10 neighbour now closed
    send(1, 12'd7, 10'd12, 1);   // R9 auto-precharge
    send(1, 12'd7, 10'd1, 0);    // R9 reopen without precharge
    send(0, 12'd6, 10'd3, 0);    // hit
    send(0, 12'd9, 10'd7, 0);    // R10 close-all again
    send(1, 12'd2, 10'd5, 1);    // R9
    send(0, 12'd4, 10'd6, 0);    // R10 single precharge, R6
    for (int n = 0; n < 80; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[0], {10'd0, lf[2:1]}, lf[12:3], lf[15] & lf[14]);
    end
    repeat (30) @(negedge clk);
    chk(cq.size() == 0, "R12", "commands left", cq.size(), 0);
    chk(dq_q.size() == 0, "R11", "words left", dq_q.size(), 0);
    finish_run();
  end
endmodule